// File: doc/BRIEF.md
# eMMC Boot Read Sequencer

This block is a hardware bus master that brings an eMMC card from power-up to data transfer without software help. It drives the register port of a card controller. First it resets and sets up that controller, then it runs the card identification commands at a slow card clock. Next it raises the card clock and selects the card. Finally it reads a requested run of 512-byte blocks, emitting each 32-bit data word on a stream output.

A start pulse captures the first block number and the block count. The block then works through a fixed script. It reports `done` for one cycle when it finishes, with `error` raised in that same cycle if a command never completed or the card was not in the transfer state before a block read. Each command is issued by clearing the interrupt register, writing the argument, then writing the command word. The block then polls the interrupt register and acknowledges the awaited flag by writing back the read value with only that flag cleared.

The register port is a simple request/ready bus. A transfer completes in the cycle where `reg_req` and `reg_ready` are both high, and read data is taken from `reg_rdata` in that same cycle.

Top module: `emmc_boot_seq`

## Requirements
- R1: After an accepted start, the first register writes are, in order: offset 0x7C ← 0x80000000, offset 0x7C ← 0x00000000, offset 0x1C ← 0x00010000, offset 0x14 ← 512, and offset 0x18 ← 0x01072FFF (slow clock).
- R2: Commands are issued in the order CMD0 (word 0x00000040, arg 0), CMD1 (0x01405040, arg 0x40300000), CMD2 (0x02806040, arg 0), CMD3 (0x03400040, arg 0x00010000), CMD9 (0x09806000, arg 0x00010000), CMD7 (0x07400000, arg 0x00010000) and CMD16 (0x10400000, arg 512). After these come the per-block commands.
- R3: Each command is three writes: offset 0x40 ← 0, offset 0x08 ← argument, offset 0x00 ← command word. Then offset 0x40 is read until bit 16 is set, and the block writes offset 0x40 ← (value read with bit 16 cleared).
- R4: After each CMD1 the block reads offset 0x2C. It reissues CMD1 until bit 31 of that value is set, then moves on to CMD2.
- R5: If POLL_LIMIT consecutive reads of offset 0x40 lack the awaited bit, the block makes no further register writes and ends with done and error high together.
- R6: Before every block, CMD13 (0x0D400000, arg 0x00010000) is issued and offset 0x2C is read. Any value other than 0x00000900 ends the run with done and error, issuing no CMD17. Blocks delivered earlier stay delivered.
- R7: Block k of the run is read with CMD17 (0x11480000, arg (first_block+k)·512), which waits for bit 16 and then bit 20 of offset 0x40, acknowledging each. Then BLOCK_WORDS reads of offset 0x34 follow. Each word read appears on `dout_data` with `dout_valid` one cycle after its transfer, in read order.
- R8: Between the acknowledge of CMD3 and the first write of CMD9, the block writes offset 0x18 ← 0x01012FFF (fast clock).
- R9: With block_count 0, the run ends after CMD16 with done high, error low, and no CMD13.
- R10: `done` is a one-cycle pulse. `error` is high only together with `done`. `busy` is high from the cycle after an accepted start until the cycle `done` rises, in which it is low.
- R11: A start pulse while `busy` is high has no effect on the running sequence or its results.
- R12: While `reg_req` is high and `reg_ready` low, the next cycle keeps `reg_req` high with `reg_we`, `reg_addr` and `reg_wdata` unchanged.
- R13: During and right after reset, `reg_req`, `busy`, `done`, `error` and `dout_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a boot read when idle |
| first_block | input | BLKNUM_W | First block number of the run |
| block_count | input | COUNT_W | Number of blocks to read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run failed; valid with done |
| dout_valid | output | 1 | Data word valid |
| dout_data | output | 32 | Data word from the card |
| reg_req | output | 1 | Register transfer request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register byte offset |
| reg_wdata | output | 32 | Write data |
| reg_ready | input | 1 | Transfer completes this cycle |
| reg_rdata | input | 32 | Read data, valid with reg_ready |

## Verification
The bench builds the block with POLL_LIMIT = 6 and BLOCK_WORDS = 16, keeping BLKNUM_W = 23 and COUNT_W = 8. The small poll limit makes the give-up path reachable in a few dozen cycles. It also allows testing both sides of the limit: a flag that appears on the sixth read still counts as success, and one that does not appear by then aborts the run. The short block keeps multi-block runs with a mid-run status failure short. The 23-bit block number lets the largest block number test the top of the 32-bit read argument.

// File: rtl/emmc_boot_pkg.sv
// Shared constants and types for the eMMC boot read sequencer.
// Assumes a controller with 32-bit registers at fixed byte offsets.
package emmc_boot_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    // Controller register offsets decoded by the controller
    localparam logic [REG_AW-1:0] OFS_CMD    = 8'h00;
    localparam logic [REG_AW-1:0] OFS_ARG    = 8'h08;
    localparam logic [REG_AW-1:0] OFS_BLKSZ  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_CLK    = 8'h18;
    localparam logic [REG_AW-1:0] OFS_ACCESS = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_RESP0  = 8'h2C;
    localparam logic [REG_AW-1:0] OFS_DATA   = 8'h34;
    localparam logic [REG_AW-1:0] OFS_INT    = 8'h40;
    localparam logic [REG_AW-1:0] OFS_CTLRST = 8'h7C;

    // Setup values
    localparam logic [REG_DW-1:0] V_RST_ON    = 32'h8000_0000;
    localparam logic [REG_DW-1:0] V_SWAP      = 32'h0001_0000;
    localparam int                BLK_BYTES   = 512;
    localparam int                BLK_SHIFT   = $clog2(BLK_BYTES);
    localparam logic [REG_DW-1:0] V_BLK_BYTES = REG_DW'(BLK_BYTES);
    localparam logic [REG_DW-1:0] V_CLK_SLOW  = 32'h0107_2FFF;
    localparam logic [REG_DW-1:0] V_CLK_FAST  = 32'h0101_2FFF;

    // Interrupt flags and response values
    localparam logic [REG_DW-1:0] F_CMD_DONE = 32'h0001_0000;
    localparam logic [REG_DW-1:0] F_RD_READY = 32'h0010_0000;
    localparam int                OCR_BUSY_N = 31;
    localparam logic [REG_DW-1:0] ST_TRAN    = 32'h0000_0900;

    // Command words and fixed arguments
    localparam logic [REG_DW-1:0] CW_GO_IDLE = 32'h0000_0040;
    localparam logic [REG_DW-1:0] CW_OCR     = 32'h0140_5040;
    localparam logic [REG_DW-1:0] CW_CID     = 32'h0280_6040;
    localparam logic [REG_DW-1:0] CW_RCA     = 32'h0340_0040;
    localparam logic [REG_DW-1:0] CW_CSD     = 32'h0980_6000;
    localparam logic [REG_DW-1:0] CW_SELECT  = 32'h0740_0000;
    localparam logic [REG_DW-1:0] CW_BLKLEN  = 32'h1040_0000;
    localparam logic [REG_DW-1:0] CW_STATUS  = 32'h0D40_0000;
    localparam logic [REG_DW-1:0] CW_READ    = 32'h1148_0000;
    localparam logic [REG_DW-1:0] A_OCR      = 32'h4030_0000;
    localparam logic [REG_DW-1:0] A_RCA      = 32'h0001_0000;

    // Script position; order follows the boot script
    typedef enum logic [3:0] {
        PH_RST_ON, PH_RST_OFF, PH_SWAP, PH_BLKSZ, PH_CLK_SLOW,
        PH_GO_IDLE, PH_OCR, PH_CID, PH_RCA, PH_CLK_FAST,
        PH_CSD, PH_SELECT, PH_BLKLEN, PH_STATUS, PH_READ
    } phase_e;

    // Bus step within a phase
    typedef enum logic [3:0] {
        S_IDLE, S_SETUP, S_CLR, S_ARG, S_CMD,
        S_POLL, S_ACK, S_RESP, S_DATA, S_END
    } step_e;

endpackage

// File: rtl/emmc_cmd_table.sv
// Script table: maps a phase to its setup write, command word,
// fixed argument, response need and linear successor.
// Purely combinational; assumes phases listed in emmc_boot_pkg.
module emmc_cmd_table
    import emmc_boot_pkg::*;
(
    input  phase_e             ph,
    output logic [REG_AW-1:0]  set_addr,
    output logic [REG_DW-1:0]  set_data,
    output logic [REG_DW-1:0]  cmd_word,
    output logic [REG_DW-1:0]  cmd_arg,
    output logic               want_resp,
    output phase_e             nxt
);

    // Decode the current phase into bus values
    always_comb begin
        set_addr  = OFS_CLK;
        set_data  = '0;
        cmd_word  = '0;
        cmd_arg   = '0;
        want_resp = 1'b0;
        nxt       = PH_STATUS;
        case (ph)
            PH_RST_ON:   begin set_addr = OFS_CTLRST; set_data = V_RST_ON;    nxt = PH_RST_OFF;  end
            PH_RST_OFF:  begin set_addr = OFS_CTLRST; set_data = '0;          nxt = PH_SWAP;     end
            PH_SWAP:     begin set_addr = OFS_ACCESS; set_data = V_SWAP;      nxt = PH_BLKSZ;    end
            PH_BLKSZ:    begin set_addr = OFS_BLKSZ;  set_data = V_BLK_BYTES; nxt = PH_CLK_SLOW; end
            PH_CLK_SLOW: begin set_addr = OFS_CLK;    set_data = V_CLK_SLOW;  nxt = PH_GO_IDLE;  end
            PH_GO_IDLE:  begin cmd_word = CW_GO_IDLE; nxt = PH_OCR; end
            PH_OCR:      begin cmd_word = CW_OCR; cmd_arg = A_OCR; want_resp = 1'b1; nxt = PH_CID; end
            PH_CID:      begin cmd_word = CW_CID; nxt = PH_RCA; end
            PH_RCA:      begin cmd_word = CW_RCA; cmd_arg = A_RCA; nxt = PH_CLK_FAST; end
            PH_CLK_FAST: begin set_addr = OFS_CLK; set_data = V_CLK_FAST; nxt = PH_CSD; end
            PH_CSD:      begin cmd_word = CW_CSD; cmd_arg = A_RCA; nxt = PH_SELECT; end
            PH_SELECT:   begin cmd_word = CW_SELECT; cmd_arg = A_RCA; nxt = PH_BLKLEN; end
            PH_BLKLEN:   begin cmd_word = CW_BLKLEN; cmd_arg = V_BLK_BYTES; nxt = PH_STATUS; end
            PH_STATUS:   begin cmd_word = CW_STATUS; cmd_arg = A_RCA; want_resp = 1'b1; nxt = PH_READ; end
            PH_READ:     begin cmd_word = CW_READ; nxt = PH_STATUS; end
            default:     begin nxt = PH_STATUS; end
        endcase
    end

endmodule

// File: rtl/emmc_poll_timer.sv
// Counts failed interrupt polls and flags the last permitted one.
// Assumes LIMIT >= 1; clears whenever polling is not active.
module emmc_poll_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic miss,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Track consecutive misses within one polling stretch
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
        end else if (miss) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The miss that uses up the limit ends the poll
    assign expired = miss && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/emmc_blk_tracker.sv
// Holds the current block number, blocks remaining and word index.
// Advances one word per data read; the last word of a block
// steps to the next block. Assumes BLOCK_WORDS >= 1.
module emmc_blk_tracker #(
    parameter int BLKNUM_W    = 23,
    parameter int COUNT_W     = 16,
    parameter int BLOCK_WORDS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [BLKNUM_W-1:0] first_block,
    input  logic [COUNT_W-1:0]  block_count,
    input  logic                word_adv,
    output logic [BLKNUM_W-1:0] cur_block,
    output logic                none_left,
    output logic                last_block,
    output logic                last_word
);

    localparam int WI_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;

    logic [COUNT_W-1:0] remaining;
    logic [WI_W-1:0]    widx;

    // Load on start, then step words and blocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_block <= '0;
            remaining <= '0;
            widx      <= '0;
        end else if (load) begin
            cur_block <= first_block;
            remaining <= block_count;
            widx      <= '0;
        end else if (word_adv) begin
            if (last_word) begin
                widx      <= '0;
                cur_block <= cur_block + 1'b1;
                remaining <= remaining - 1'b1;
            end else begin
                widx <= widx + 1'b1;
            end
        end
    end

    assign none_left  = (remaining == '0);
    assign last_block = (remaining == COUNT_W'(1));
    assign last_word  = (widx == WI_W'(BLOCK_WORDS - 1));

endmodule

// File: rtl/emmc_boot_seq.sv
// eMMC boot read sequencer top. Walks a fixed controller setup and
// card command script over a request/ready register bus, then
// streams BLOCK_WORDS words per block. Assumes the controller
// completes each transfer in the cycle reg_ready is high.
module emmc_boot_seq
    import emmc_boot_pkg::*;
#(
    parameter int POLL_LIMIT  = 1000000,
    parameter int BLOCK_WORDS = 128,
    parameter int BLKNUM_W    = 23,
    parameter int COUNT_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [BLKNUM_W-1:0] first_block,
    input  logic [COUNT_W-1:0]  block_count,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic                dout_valid,
    output logic [REG_DW-1:0]   dout_data,
    output logic                reg_req,
    output logic                reg_we,
    output logic [REG_AW-1:0]   reg_addr,
    output logic [REG_DW-1:0]   reg_wdata,
    input  logic                reg_ready,
    input  logic [REG_DW-1:0]   reg_rdata
);

    step_e             st;
    phase_e            ph;
    phase_e            nxt_ph;
    logic [REG_DW-1:0] snap;
    logic              hi_flag;
    logic              fail_q;
    logic              done_q;
    logic              err_q;
    logic              dv_q;
    logic [REG_DW-1:0] dd_q;

    logic [REG_AW-1:0] set_addr;
    logic [REG_DW-1:0] set_data;
    logic [REG_DW-1:0] cmd_word;
    logic [REG_DW-1:0] tbl_arg;
    logic [REG_DW-1:0] cmd_arg;
    logic              want_resp;
    logic [REG_DW-1:0] poll_mask;
    logic              xfer;
    logic              hit;
    logic              expired;
    logic [BLKNUM_W-1:0] cur_block;
    logic              none_left;
    logic              last_block;
    logic              last_word;

    emmc_cmd_table tbl_i (
        .ph        (ph),
        .set_addr  (set_addr),
        .set_data  (set_data),
        .cmd_word  (cmd_word),
        .cmd_arg   (tbl_arg),
        .want_resp (want_resp),
        .nxt       (nxt_ph)
    );

    emmc_poll_timer #(.LIMIT(POLL_LIMIT)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (st == S_POLL),
        .miss    ((st == S_POLL) && xfer && !hit),
        .expired (expired)
    );

    emmc_blk_tracker #(
        .BLKNUM_W    (BLKNUM_W),
        .COUNT_W     (COUNT_W),
        .BLOCK_WORDS (BLOCK_WORDS)
    ) trk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        ((st == S_IDLE) && start),
        .first_block (first_block),
        .block_count (block_count),
        .word_adv    ((st == S_DATA) && xfer),
        .cur_block   (cur_block),
        .none_left   (none_left),
        .last_block  (last_block),
        .last_word   (last_word)
    );

    assign xfer      = reg_req && reg_ready;
    assign poll_mask = hi_flag ? F_RD_READY : F_CMD_DONE;
    assign hit       = |(reg_rdata & poll_mask);
    assign cmd_arg   = (ph == PH_READ) ? (REG_DW'(cur_block) << BLK_SHIFT) : tbl_arg;

    // Drive the register bus from the current step
    always_comb begin
        reg_req   = 1'b1;
        reg_we    = 1'b0;
        reg_addr  = OFS_INT;
        reg_wdata = '0;
        case (st)
            S_SETUP: begin reg_we = 1'b1; reg_addr = set_addr; reg_wdata = set_data; end
            S_CLR:   begin reg_we = 1'b1; reg_addr = OFS_INT; end
            S_ARG:   begin reg_we = 1'b1; reg_addr = OFS_ARG; reg_wdata = cmd_arg; end
            S_CMD:   begin reg_we = 1'b1; reg_addr = OFS_CMD; reg_wdata = cmd_word; end
            S_POLL:  begin reg_addr = OFS_INT; end
            S_ACK:   begin reg_we = 1'b1; reg_addr = OFS_INT; reg_wdata = snap & ~poll_mask; end
            S_RESP:  begin reg_addr = OFS_RESP0; end
            S_DATA:  begin reg_addr = OFS_DATA; end
            default: begin reg_req = 1'b0; end
        endcase
    end

    // Script sequencing, completion and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            ph      <= PH_RST_ON;
            snap    <= '0;
            hi_flag <= 1'b0;
            fail_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            dv_q    <= 1'b0;
            dd_q    <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            dv_q   <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    st     <= S_SETUP;
                    ph     <= PH_RST_ON;
                    fail_q <= 1'b0;
                end
                S_SETUP: if (xfer) begin
                    ph <= nxt_ph;
                    st <= (ph == PH_CLK_SLOW || ph == PH_CLK_FAST) ? S_CLR : S_SETUP;
                end
                S_CLR: if (xfer) st <= S_ARG;
                S_ARG: if (xfer) st <= S_CMD;
                S_CMD: if (xfer) begin
                    st      <= S_POLL;
                    hi_flag <= 1'b0;
                end
                S_POLL: if (xfer) begin
                    if (hit) begin
                        snap <= reg_rdata;
                        st   <= S_ACK;
                    end else if (expired) begin
                        fail_q <= 1'b1;
                        st     <= S_END;
                    end
                end
                S_ACK: if (xfer) begin
                    if (ph == PH_READ && !hi_flag) begin
                        hi_flag <= 1'b1;
                        st      <= S_POLL;
                    end else if (ph == PH_READ) begin
                        st <= S_DATA;
                    end else if (want_resp) begin
                        st <= S_RESP;
                    end else if (ph == PH_RCA) begin
                        ph <= nxt_ph;
                        st <= S_SETUP;
                    end else if (ph == PH_BLKLEN && none_left) begin
                        st <= S_END;
                    end else begin
                        ph <= nxt_ph;
                        st <= S_CLR;
                    end
                end
                S_RESP: if (xfer) begin
                    if (ph == PH_OCR) begin
                        if (reg_rdata[OCR_BUSY_N]) ph <= nxt_ph;
                        st <= S_CLR;
                    end else if (reg_rdata == ST_TRAN) begin
                        ph <= nxt_ph;
                        st <= S_CLR;
                    end else begin
                        fail_q <= 1'b1;
                        st     <= S_END;
                    end
                end
                S_DATA: if (xfer) begin
                    dv_q <= 1'b1;
                    dd_q <= reg_rdata;
                    if (last_word) begin
                        if (last_block) begin
                            st <= S_END;
                        end else begin
                            ph <= PH_STATUS;
                            st <= S_CLR;
                        end
                    end
                end
                S_END: begin
                    done_q <= 1'b1;
                    err_q  <= fail_q;
                    st     <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy       = (st != S_IDLE);
    assign done       = done_q;
    assign error      = err_q;
    assign dout_valid = dv_q;
    assign dout_data  = dd_q;

endmodule

// File: rtl/emmc_boot_seq_chk.sv
// Protocol checker for emmc_boot_seq, bound to every instance.
// Observes ports only; assumes synchronous active-low reset.
module emmc_boot_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic        dout_valid,
    input logic        reg_req,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        reg_ready
);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ready |=> reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata));

    assert_err_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !reg_req);

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    assert_data_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> busy);

    assert_req_in_run_R13: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> busy);

endmodule

bind emmc_boot_seq emmc_boot_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .dout_valid (dout_valid),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_ready  (reg_ready)
);

// File: tb/emmc_boot_seq_tb_top.sv
// Bench for emmc_boot_seq: a register-level controller responder,
// a vector table of runs, then directed reset and start tests.
module emmc_boot_seq_tb_top;

    localparam int PL  = 6;
    localparam int BW  = 16;
    localparam int BNW = 23;
    localparam int CNW = 8;

    typedef struct packed {
        logic [22:0] first;
        logic [7:0]  nblk;
        logic [7:0]  retries;
        logic [7:0]  delay;
        logic [7:0]  failidx;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{23'd0,       8'd1, 8'd0, 8'd0, 8'hFF},
        '{23'd5,       8'd3, 8'd2, 8'd2, 8'hFF},
        '{23'h7FFFFF,  8'd1, 8'd0, 8'd5, 8'hFF},
        '{23'd10,      8'd3, 8'd1, 8'd0, 8'd1 },
        '{23'd3,       8'd0, 8'd0, 8'd1, 8'hFF},
        '{23'd0,       8'd2, 8'd0, 8'd6, 8'hFF}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [BNW-1:0]  first_block = '0;
    logic [CNW-1:0]  block_count = '0;
    logic            busy, done, error, dout_valid;
    logic [31:0]     dout_data;
    logic            reg_req, reg_we;
    logic [7:0]      reg_addr;
    logic [31:0]     reg_wdata;
    logic            reg_ready = 1'b0;
    logic [31:0]     reg_rdata = '0;

    int checks = 0;
    int errors = 0;

    // Responder state and knobs
    logic [31:0] int_reg = '0;
    logic [31:0] arm_bits = '0;
    logic        armed = 1'b0;
    int          pend = 0;
    logic [31:0] last_cmd = '0;
    logic [31:0] last_arg = '0;
    logic [31:0] data_blk = '0;
    int          word_idx = 0;
    int          cmd1_cnt = 0;
    int          cmd13_cnt = 0;
    int          k_delay = 0;
    int          k_retries = 0;
    int          k_fail = -1;
    int          rdy_cnt = 0;

    // Logs and expectations
    logic [7:0]  wl_a [0:255];
    logic [31:0] wl_d [0:255];
    int          wl_n = 0;
    logic [7:0]  ex_a [0:255];
    logic [31:0] ex_d [0:255];
    int          ex_n = 0;
    int          got_words = 0;
    int          bad_words = 0;
    logic [31:0] first_bad = '0;
    logic [31:0] mon_first = '0;

    always #2 clk = ~clk;

    emmc_boot_seq #(
        .POLL_LIMIT  (PL),
        .BLOCK_WORDS (BW),
        .BLKNUM_W    (BNW),
        .COUNT_W     (CNW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .first_block (first_block),
        .block_count (block_count),
        .busy        (busy),
        .done        (done),
        .error       (error),
        .dout_valid  (dout_valid),
        .dout_data   (dout_data),
        .reg_req     (reg_req),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_ready   (reg_ready),
        .reg_rdata   (reg_rdata)
    );

    // Monitor the stream, then answer the bus for the coming edge
    always @(negedge clk) begin
        if (dout_valid) begin
            logic [31:0] expw;
            expw = {16'(mon_first + 32'(got_words / BW)), 16'(got_words % BW)};
            if (dout_data !== expw && bad_words == 0) first_bad = dout_data;
            if (dout_data !== expw) bad_words++;
            got_words++;
        end
        rdy_cnt++;
        reg_ready = rst_n && ((rdy_cnt % 3) != 2);
        reg_rdata = '0;
        if (reg_ready && reg_req) begin
            if (reg_we) begin
                wl_a[wl_n] = reg_addr;
                wl_d[wl_n] = reg_wdata;
                if (wl_n < 255) wl_n++;
                if (reg_addr == 8'h40) int_reg = int_reg & reg_wdata;
                if (reg_addr == 8'h08) last_arg = reg_wdata;
                if (reg_addr == 8'h00) begin
                    last_cmd = reg_wdata;
                    armed    = 1'b1;
                    pend     = k_delay;
                    arm_bits = (reg_wdata == 32'h1148_0000) ? 32'h0011_0001 : 32'h0001_0001;
                    if (reg_wdata == 32'h0140_5040) cmd1_cnt++;
                    if (reg_wdata == 32'h0D40_0000) cmd13_cnt++;
                    if (reg_wdata == 32'h1148_0000) begin
                        data_blk = last_arg >> 9;
                        word_idx = 0;
                    end
                end
            end else begin
                case (reg_addr)
                    8'h40: begin
                        if (armed) begin
                            if (pend == 0) begin
                                int_reg = int_reg | arm_bits;
                                armed   = 1'b0;
                            end else begin
                                pend--;
                            end
                        end
                        reg_rdata = int_reg;
                    end
                    8'h2C: begin
                        if (last_cmd == 32'h0140_5040)
                            reg_rdata = (cmd1_cnt > k_retries) ? 32'h80FF_8000 : 32'h00FF_8000;
                        else if (last_cmd == 32'h0D40_0000)
                            reg_rdata = ((cmd13_cnt - 1) == k_fail) ? 32'h0000_0800 : 32'h0000_0900;
                    end
                    8'h34: begin
                        reg_rdata = {data_blk[15:0], 16'(word_idx)};
                        word_idx++;
                    end
                    default: reg_rdata = '0;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [31:0] d);
        ex_a[ex_n] = a;
        ex_d[ex_n] = d;
        ex_n++;
    endtask

    task automatic push_cmd(input logic [31:0] w, input logic [31:0] arg);
        push(8'h40, 32'h0);
        push(8'h08, arg);
        push(8'h00, w);
        push(8'h40, 32'h0000_0001);
    endtask

    // Expected write log derived from R1-style rules per scenario
    task automatic build_expected(input vec_t v);
        ex_n = 0;
        push(8'h7C, 32'h8000_0000);
        push(8'h7C, 32'h0);
        push(8'h1C, 32'h0001_0000);
        push(8'h14, 32'd512);
        push(8'h18, 32'h0107_2FFF);
        if (int'(v.delay) >= PL) begin
            push(8'h40, 32'h0);
            push(8'h08, 32'h0);
            push(8'h00, 32'h0000_0040);
            return;
        end
        push_cmd(32'h0000_0040, 32'h0);
        for (int r = 0; r <= int'(v.retries); r++) push_cmd(32'h0140_5040, 32'h4030_0000);
        push_cmd(32'h0280_6040, 32'h0);
        push_cmd(32'h0340_0040, 32'h0001_0000);
        push(8'h18, 32'h0101_2FFF);
        push_cmd(32'h0980_6000, 32'h0001_0000);
        push_cmd(32'h0740_0000, 32'h0001_0000);
        push_cmd(32'h1040_0000, 32'd512);
        for (int b = 0; b < int'(v.nblk); b++) begin
            push_cmd(32'h0D40_0000, 32'h0001_0000);
            if (b == int'(v.failidx)) return;
            push(8'h40, 32'h0);
            push(8'h08, (32'(v.first) + 32'(b)) << 9);
            push(8'h00, 32'h1148_0000);
            push(8'h40, 32'h0010_0001);
            push(8'h40, 32'h0000_0001);
        end
    endtask

    task automatic reset_responder(input vec_t v);
        k_delay   = int'(v.delay);
        k_retries = int'(v.retries);
        k_fail    = (v.failidx == 8'hFF) ? -1 : int'(v.failidx);
        cmd1_cnt  = 0;
        cmd13_cnt = 0;
        int_reg   = '0;
        armed     = 1'b0;
        last_cmd  = '0;
        wl_n      = 0;
        got_words = 0;
        bad_words = 0;
        mon_first = 32'(v.first);
    endtask

    task automatic run_scn(input vec_t v, input bit extra);
        bit    tmo;
        bit    fl;
        bit    exp_err;
        int    exp_words;
        int    mism;
        string etag;
        @(negedge clk);
        reset_responder(v);
        build_expected(v);
        tmo = int'(v.delay) >= PL;
        fl  = (v.failidx != 8'hFF) && (v.failidx < v.nblk);
        exp_err   = tmo || fl;
        exp_words = tmo ? 0 : (fl ? int'(v.failidx) * BW : int'(v.nblk) * BW);
        etag = tmo ? "R5" : (fl ? "R6" : ((v.nblk == 0) ? "R9" : "R10"));
        first_block = v.first;
        block_count = v.nblk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", 32'(busy), 32'd1);
        if (extra) begin
            repeat (20) @(negedge clk);
            first_block = 23'd99;
            block_count = 8'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(error === exp_err, {etag, " error flag at done"}, 32'(error), 32'(exp_err));
        chk(busy === 1'b0, "R10 busy low with done", 32'(busy), 32'd0);
        @(negedge clk);
        chk(done === 1'b0 && error === 1'b0, "R10 done pulse width", 32'(done), 32'd0);
        chk(wl_n == ex_n, "R1/R2/R3/R5/R6 write count", 32'(wl_n), 32'(ex_n));
        mism = -1;
        for (int i = 0; i < ex_n && i < wl_n; i++)
            if (mism < 0 && (wl_a[i] !== ex_a[i] || wl_d[i] !== ex_d[i])) mism = i;
        if (mism >= 0)
            chk(1'b0, (mism < 5) ? "R1 setup write" : "R2/R3/R7/R8 command write",
                {wl_a[mism][7:0], wl_d[mism][23:0]}, {ex_a[mism][7:0], ex_d[mism][23:0]});
        else
            chk(1'b1, "R2/R3 write log", 32'd0, 32'd0);
        chk(got_words == exp_words, "R7 word count", 32'(got_words), 32'(exp_words));
        chk(bad_words == 0, "R7 word content", first_bad, 32'd0);
        if (!tmo)
            chk(cmd1_cnt == k_retries + 1, "R4 CMD1 issues", 32'(cmd1_cnt), 32'(k_retries + 1));
        if (extra)
            chk(got_words == exp_words && wl_n == ex_n, "R11 start ignored while busy",
                32'(got_words), 32'(exp_words));
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(reg_req === 1'b0 && busy === 1'b0, "R13 reset bus idle", {30'd0, reg_req, busy}, 32'd0);
        chk(done === 1'b0 && error === 1'b0 && dout_valid === 1'b0, "R13 reset outputs",
            {29'd0, done, error, dout_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 6; i++) run_scn(VECS[i], 1'b0);

        // R11: extra start mid-run must not disturb the run
        run_scn(VECS[1], 1'b1);

        // R13: reset in mid-run returns the block to idle
        @(negedge clk);
        reset_responder(VECS[0]);
        first_block = '0;
        block_count = 8'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(reg_req === 1'b0 && busy === 1'b0 && dout_valid === 1'b0, "R13 mid-run reset",
            {29'd0, reg_req, busy, dout_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Recovery after reset, with an all-good run
        run_scn(VECS[0], 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule